// File: doc/BRIEF.md
# Vertical Scanout Position Tracker

This block follows the vertical timing of one display interface. Each pulse on the line strobe moves a line counter forward by one. The count is 1 on the first line of the vertical sync pulse. It runs up to the programmed total line count and then returns to 1. Each time the line counter returns to 1, a frame counter adds one. The frame counter is FRAME_W bits wide and wraps to zero after its largest value.

From the raw line number, combinational logic derives four outputs: a signed vertical scanout position, a vertical-blank flag, a sync level, and a horizontal position that is always zero. The position is laid out so that all blanking lines form one unbroken run of negative values. The run covers the front porch at the end of one frame, then the sync and back porch of the next frame, and it reaches zero on the first active line.

A timestamp unit or a frame-pacing unit reads these outputs to find where the raster is. A two-bit control enables the frame counter and the line counter separately. Writing 3 to it starts both.

Top module: `scan_tracker`

## Requirements
- R1: After reset, the line count is 1, the frame count is 0 and the sync output is high (for a sync width of at least 1).
- R2: When the line counter is enabled (cnt_en bit 1 = 1), each cycle with line_stb high raises the line count by one. A strobe taken while the count is at or above total_lines sets it to 1 instead.
- R3: When cnt_en bit 1 is 0, the line count holds its value and line strobes have no effect. No wrap occurs, so the frame count does not change either.
- R4: The frame count rises by exactly one in the cycle after the line counter wraps to 1, and only if cnt_en bit 0 is 1. Otherwise the frame count holds its value.
- R5: The first active line is A = sync_lines + bporch_lines + 1. For raw lines below A, vpos = line − A and in_vblank = 1.
- R6: The end threshold is E = A + active_lines. For raw lines strictly above E, vpos = line − total_lines − A and in_vblank = 1.
- R7: For raw lines from A to E inclusive, vpos = line − A (non-negative) and in_vblank = 0. A line equal to E counts as active.
- R8: vsync is high exactly when the raw line lies in 1..sync_lines, inclusive.
- R9: hpos reads zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per scan line |
| cnt_en | input | 2 | Bit 0: frame counter enable. Bit 1: line counter enable |
| sync_lines | input | LINE_W | Vertical sync width, in lines |
| bporch_lines | input | LINE_W | Vertical back porch, in lines |
| active_lines | input | LINE_W | Active height, in lines |
| total_lines | input | LINE_W | Total lines per frame |
| line_cnt | output | LINE_W | Raw line number, counted from 1 |
| frame_cnt | output | FRAME_W | Frame count |
| vpos | output | POS_W | Signed vertical position, two's complement |
| in_vblank | output | 1 | High during vertical blanking |
| vsync | output | 1 | Vertical sync level |
| hpos | output | POS_W | Horizontal position, always zero |

## Verification
The assertions check the counter rules on every cycle. They cover the single-step advance, the return to 1 after a wrap, holding the count when no enabled strobe arrives, and the frame step and hold. They also check that sync lines always report blanking and that active lines never report a negative position. The exact position values across the whole frame can only be shown by the bench's directed scenarios. These include the continuous negative run from the front porch into the next frame's sync, the boundary line E being active, the enable combinations, and a second, tighter timing setup.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int EN_FRAME_BIT = 0;
    localparam int EN_LINE_BIT  = 1;

    typedef enum logic [1:0] {
        RGN_LEAD   = 2'd0,
        RGN_ACTIVE = 2'd1,
        RGN_TAIL   = 2'd2
    } region_e;
endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_stb,
    input  logic              line_en,
    input  logic [LINE_W-1:0] total_lines,
    output logic [LINE_W-1:0] line_q_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
    } line_state_t;

    line_state_t st_d, st_q;
    logic        adv;

    always_comb begin
        st_d   = st_q;
        adv    = line_stb && line_en;
        wrap_o = adv && (st_q.line >= total_lines);
        if (adv) begin
            if (wrap_o) st_d.line = LINE_W'(1);
            else        st_d.line = st_q.line + LINE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.line <= LINE_W'(1);
        else        st_q <= st_d;
    end

    assign line_q_o = st_q.line;

    // R2: a wrap lands on line 1
    p_wrap_to_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && line_en && (line_q_o >= total_lines)) |=> (line_q_o == LINE_W'(1)));
    // R2: an ordinary advance moves by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && line_en && (line_q_o < total_lines)) |=> (line_q_o == $past(line_q_o) + LINE_W'(1)));
    // R3: no enabled strobe, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_stb && line_en) |=> $stable(line_q_o));
endmodule

// File: rtl/scan_frame_ctr.sv
module scan_frame_ctr #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrap,
    input  logic               frame_en,
    output logic [FRAME_W-1:0] frame_q_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
    } frame_state_t;

    frame_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap && frame_en) st_d.frame = st_q.frame + FRAME_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.frame <= '0;
        else        st_q <= st_d;
    end

    assign frame_q_o = st_q.frame;

    // R4: step by one on an enabled wrap, wrapping modulo 2^FRAME_W
    p_frame_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && frame_en) |=> (frame_q_o == $past(frame_q_o) + FRAME_W'(1)));
    // R4: otherwise hold
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap && frame_en) |=> $stable(frame_q_o));
endmodule

// File: rtl/scan_pos_map.sv
module scan_pos_map
    import scan_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int POS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] sync_lines,
    input  logic [LINE_W-1:0] bporch_lines,
    input  logic [LINE_W-1:0] active_lines,
    input  logic [LINE_W-1:0] total_lines,
    output logic signed [POS_W-1:0] vpos,
    output region_e           region,
    output logic              vsync
);
    localparam int CW = LINE_W + 3;

    logic signed [CW-1:0] s_line, s_start, s_end, s_total, s_sync, diff;

    always_comb begin
        s_line  = signed'({3'b000, line});
        s_sync  = signed'({3'b000, sync_lines});
        s_total = signed'({3'b000, total_lines});
        s_start = s_sync + signed'({3'b000, bporch_lines}) + CW'(1);
        s_end   = s_start + signed'({3'b000, active_lines});
        if (s_line < s_start) begin
            region = RGN_LEAD;
            diff   = s_line - s_start;
        end else if (s_line > s_end) begin
            region = RGN_TAIL;
            diff   = s_line - s_total - s_start;
        end else begin
            region = RGN_ACTIVE;
            diff   = s_line - s_start;
        end
        vpos  = POS_W'(diff);
        vsync = (s_line >= CW'(1)) && (s_line <= s_sync);
    end

    // R8/R5: a sync line always lies in blanking
    p_sync_is_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> (region != RGN_ACTIVE));
    // R7: active lines never give a negative position
    p_active_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_ACTIVE) |-> !vpos[POS_W-1]);
endmodule

// File: rtl/scan_tracker.sv
module scan_tracker
    import scan_pkg::*;
#(
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 32,
    parameter int POS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_stb,
    input  logic [1:0]         cnt_en,
    input  logic [LINE_W-1:0]  sync_lines,
    input  logic [LINE_W-1:0]  bporch_lines,
    input  logic [LINE_W-1:0]  active_lines,
    input  logic [LINE_W-1:0]  total_lines,
    output logic [LINE_W-1:0]  line_cnt,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic [POS_W-1:0]   vpos,
    output logic               in_vblank,
    output logic               vsync,
    output logic [POS_W-1:0]   hpos
);
    logic    wrap;
    region_e region;
    logic signed [POS_W-1:0] vpos_s;

    scan_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .line_en(cnt_en[EN_LINE_BIT]), .total_lines(total_lines),
        .line_q_o(line_cnt), .wrap_o(wrap)
    );

    scan_frame_ctr #(.FRAME_W(FRAME_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .wrap(wrap),
        .frame_en(cnt_en[EN_FRAME_BIT]), .frame_q_o(frame_cnt)
    );

    scan_pos_map #(.LINE_W(LINE_W), .POS_W(POS_W)) u_map (
        .clk(clk), .rst_n(rst_n), .line(line_cnt),
        .sync_lines(sync_lines), .bporch_lines(bporch_lines),
        .active_lines(active_lines), .total_lines(total_lines),
        .vpos(vpos_s), .region(region), .vsync(vsync)
    );

    assign vpos      = vpos_s;
    assign in_vblank = (region != RGN_ACTIVE);
    assign hpos      = '0;

    // R4: the frame count only moves while the line counter is enabled
    p_frame_needs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en[EN_LINE_BIT] |=> $stable(frame_cnt));
endmodule

// File: tb/sim_scan_tracker.sv
module sim_scan_tracker;
    localparam int LW = 12;
    localparam int FW = 32;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_stb = 1'b0;
    logic [1:0]    cnt_en = 2'b11;
    logic [LW-1:0] sync_lines = 12'd2, bporch_lines = 12'd3;
    logic [LW-1:0] active_lines = 12'd5, total_lines = 12'd14;
    logic [LW-1:0] line_cnt;
    logic [FW-1:0] frame_cnt;
    logic [PW-1:0] vpos, hpos;
    logic          in_vblank, vsync;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    scan_tracker #(.LINE_W(LW), .FRAME_W(FW), .POS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cnt_en(cnt_en),
        .sync_lines(sync_lines), .bporch_lines(bporch_lines),
        .active_lines(active_lines), .total_lines(total_lines),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt), .vpos(vpos),
        .in_vblank(in_vblank), .vsync(vsync), .hpos(hpos)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int s, input int b, input int a, input int t);
        @(negedge clk);
        rst_n = 1'b0;
        sync_lines = LW'(s); bporch_lines = LW'(b);
        active_lines = LW'(a); total_lines = LW'(t);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_stb = 1'b1;
            @(negedge clk); line_stb = 1'b0;
        end
    endtask

    // expected position decode straight from R5..R8
    task automatic check_line(input int ln);
        int st, en, ev, eb, es;
        st = int'(sync_lines) + int'(bporch_lines) + 1;
        en = st + int'(active_lines);
        if (ln < st)      begin ev = ln - st;                    eb = 1; end
        else if (ln > en) begin ev = ln - int'(total_lines) - st; eb = 1; end
        else              begin ev = ln - st;                    eb = 0; end
        es = (ln >= 1 && ln <= int'(sync_lines)) ? 1 : 0;
        chk(ln < st ? "R5 vpos" : (ln > en ? "R6 vpos" : "R7 vpos"),
            longint'($signed(vpos)), longint'(ev));
        chk(eb == 1 ? "R5/R6 blank" : "R7 blank", longint'(in_vblank), longint'(eb));
        chk("R8 vsync", longint'(vsync), longint'(es));
        chk("R9 hpos", longint'(hpos), 0);
    endtask

    task automatic t_reset();
        do_reset(2, 3, 5, 14);
        @(negedge clk);
        chk("R1 line", longint'(line_cnt), 1);
        chk("R1 frame", longint'(frame_cnt), 0);
        chk("R1 vsync", longint'(vsync), 1);
    endtask

    task automatic t_full_frame(input int s, input int b, input int a, input int t);
        do_reset(s, b, a, t);
        cnt_en = 2'b11;
        check_line(1);
        for (int ln = 2; ln <= t; ln++) begin
            strobe(1);
            chk("R2 line", longint'(line_cnt), longint'(ln));
            check_line(ln);
        end
        chk("R4 frame before wrap", longint'(frame_cnt), 0);
        strobe(1);
        chk("R2 wrap", longint'(line_cnt), 1);
        chk("R4 frame after wrap", longint'(frame_cnt), 1);
        check_line(1);
        strobe(t);
        chk("R4 second frame", longint'(frame_cnt), 2);
    endtask

    task automatic t_line_disabled();
        do_reset(2, 3, 5, 14);
        cnt_en = 2'b11;
        strobe(4);
        chk("R2 line", longint'(line_cnt), 5);
        cnt_en = 2'b01;
        strobe(20);
        chk("R3 line hold", longint'(line_cnt), 5);
        chk("R3 frame hold", longint'(frame_cnt), 0);
        check_line(5);
        cnt_en = 2'b11;
        repeat (4) @(negedge clk);
        chk("R2 no strobe hold", longint'(line_cnt), 5);
    endtask

    task automatic t_frame_disabled();
        do_reset(2, 3, 5, 14);
        cnt_en = 2'b10;
        strobe(14);
        chk("R2 wrap", longint'(line_cnt), 1);
        chk("R4 frame gated", longint'(frame_cnt), 0);
        cnt_en = 2'b11;
        strobe(14);
        chk("R4 frame enabled", longint'(frame_cnt), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_frame(2, 3, 5, 14);
        t_full_frame(1, 0, 2, 6);
        t_line_disabled();
        t_frame_disabled();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule